// File: doc/BRIEF.md
# Programmable Line Pulse Phase Sequencer

This block drives the amplitude input of a programmable line pulse shaper. Each transmitted bit period (unit interval, UI) is divided into equal sub-intervals called phases. On every phase tick the block emits one signed amplitude code. That code is the sum of the waveforms of all recent marks at the current phase.

A host loads a table of signed amplitudes, indexed by UI offset and phase, through a simple write port. At the start of every UI the block samples the next bit of the outgoing stream. A mark launches the programmed waveform with alternating polarity. The waveform spans several UIs, so the tails of earlier marks add to the current one to shape the rising and falling edges. The sum is clamped to the signed full-scale range, and any clamping sets a sticky overflow flag that the host can clear.

A four-bit line configuration code selects between a 14-phase layout and a 13-phase layout. Any other code turns arbitrary shaping off.

Top module: `pulse_phase_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `amp_out` is 0, `amp_stb` is 0 and `ovf_flag` is 0.
- R2: `amp_stb` is high for exactly the cycle after each cycle in which `phase_tick` is high. `amp_out` changes only in such a cycle.
- R3: A `line_cfg` of 4'b1010 or 4'b1011 gives 14 phases per UI. A `line_cfg` of 4'b1001 gives 13 phases per UI, and in that mode table entries with phase index 13 never reach `amp_out`.
- R4: With any other `line_cfg` code, every tick yields `amp_out` = 0, no mark is launched, earlier marks are discarded, and `ovf_flag` is not set.
- R5: The phase counter wraps to phase 0 on the tick that follows the last phase. On that tick `tx_mark` is sampled as the new bit, and the output after that tick is phase 0 of UI offset 0.
- R6: Marks alternate polarity, and the first mark after reset is positive. A space contributes zero and does not change the polarity.
- R7: A mark launched k UIs ago (k = 0 to 4) adds its polarity times table[k][phase] to the output. The contributions of all five offsets are summed.
- R8: A sum above +127 is output as +127, and a sum below -128 is output as -128.
- R9: `ovf_flag` is set by any tick whose sum was clamped. It stays set until a cycle with `ovf_clr` high. When a clamp and a clear happen in the same cycle, the flag stays set.
- R10: With `tbl_wr_en` high, `tbl_wr_data` is stored at UI offset `tbl_wr_ui` and phase `tbl_wr_ph`. A write with an offset of 5 or more, or a phase of 14 or more, is ignored.
- R11: After reset the counter stands at phase 0 with no mark in flight. The first bit is therefore sampled on the 14th tick in 14-phase mode, or the 13th tick in 13-phase mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_tick | input | 1 | One-cycle pulse that advances to the next phase |
| tx_mark | input | 1 | Outgoing bit (1 = mark), sampled at UI start |
| line_cfg | input | 4 | Configuration code that selects the phase count or turns shaping off |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_ui | input | 3 | Table write UI offset |
| tbl_wr_ph | input | 4 | Table write phase index |
| tbl_wr_data | input | 8 | Signed amplitude to store |
| ovf_clr | input | 1 | Clears the overflow flag |
| amp_out | output | 8 | Signed amplitude code for the current phase |
| amp_stb | output | 1 | High for the cycle in which a new `amp_out` is presented |
| ovf_flag | output | 1 | Sticky saturation flag |

## Verification
Each kind of wrong internal state shows up at the ports within a bounded time:

- **Phase counter off by one:** a wrong wrap point shifts the whole waveform by a phase. The first strobe after the intended UI start shows it.
- **Polarity or history register fault:** a bit wrong here flips or drops a contribution. This appears at the next phase where the table entry at that offset is nonzero, so within one UI of the launch. It can persist for up to five UIs.
- **Stale overflow latch:** visible on the very next strobe, because the flag is compared at every phase.
- **Leaked 13-phase entry:** the bench loads full-scale values into phase 13 of every offset. If any of them reaches the output, it shows as a large jump in the output.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;

    localparam int CFG_W = 4;

    // Configuration codes that enable arbitrary shaping
    localparam logic [CFG_W-1:0] CFG_SHORT  = 4'b1001;
    localparam logic [CFG_W-1:0] CFG_LONG_A = 4'b1010;
    localparam logic [CFG_W-1:0] CFG_LONG_B = 4'b1011;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_LONG  = 2'd1,
        MODE_SHORT = 2'd2
    } mode_t;

    // One history slot: did a mark launch, and with which sign
    typedef struct packed {
        logic mark;
        logic neg;
    } pol_t;

    function automatic mode_t decode_cfg(input logic [CFG_W-1:0] cfg);
        mode_t m;
        case (cfg)
            CFG_SHORT:              m = MODE_SHORT;
            CFG_LONG_A, CFG_LONG_B: m = MODE_LONG;
            default:                m = MODE_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pps_phase_ctr.sv
`timescale 1ns/1ps
module pps_phase_ctr #(
    parameter int PH_LONG  = 14,
    parameter int PH_SHORT = 13,
    localparam int PH_W    = $clog2(PH_LONG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  pps_pkg::mode_t    mode,
    output logic [PH_W-1:0]   ph_q,
    output logic [PH_W-1:0]   ph_nxt,
    output logic              wrap
);
    import pps_pkg::*;

    localparam logic [PH_W-1:0] LAST_LONG  = PH_W'(PH_LONG - 1);
    localparam logic [PH_W-1:0] LAST_SHORT = PH_W'(PH_SHORT - 1);

    logic [PH_W-1:0] last_c;

    always_comb begin
        last_c = (mode == MODE_SHORT) ? LAST_SHORT : LAST_LONG;
        // A counter left beyond the last phase by a mode change wraps at once
        wrap   = (ph_q >= last_c);
        ph_nxt = wrap ? '0 : ph_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '0;
        end else if (tick) begin
            ph_q <= ph_nxt;
        end
    end

endmodule

// File: rtl/pps_mark_hist.sv
`timescale 1ns/1ps
module pps_mark_hist #(
    parameter int SPAN = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    input  logic                          wrap,
    input  logic                          active,
    input  logic                          mark,
    output pps_pkg::pol_t [SPAN-1:0]      hist_q,
    output pps_pkg::pol_t [SPAN-1:0]      hist_nxt
);
    import pps_pkg::*;

    logic neg_q;
    logic neg_nxt;

    always_comb begin
        hist_nxt = hist_q;
        neg_nxt  = neg_q;
        if (!active) begin
            hist_nxt = '0;
        end else if (wrap) begin
            for (int k = SPAN - 1; k > 0; k--) begin
                hist_nxt[k] = hist_q[k-1];
            end
            hist_nxt[0].mark = mark;
            hist_nxt[0].neg  = mark & neg_q;
            neg_nxt          = neg_q ^ mark;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            neg_q  <= 1'b0;
        end else if (tick) begin
            hist_q <= hist_nxt;
            neg_q  <= neg_nxt;
        end
    end

endmodule

// File: rtl/pps_wave_tbl.sv
`timescale 1ns/1ps
module pps_wave_tbl #(
    parameter int AMP_W   = 8,
    parameter int SPAN    = 5,
    parameter int PH_LONG = 14,
    localparam int UI_W   = $clog2(SPAN),
    localparam int PH_W   = $clog2(PH_LONG)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [UI_W-1:0]                 wr_ui,
    input  logic [PH_W-1:0]                 wr_ph,
    input  logic [AMP_W-1:0]                wr_data,
    input  logic [PH_W-1:0]                 rd_ph,
    output logic [SPAN-1:0][AMP_W-1:0]      rd_amp
);

    logic [AMP_W-1:0] mem [SPAN][PH_LONG];
    logic             wr_ok;

    assign wr_ok = wr_en && (32'(wr_ui) < SPAN) && (32'(wr_ph) < PH_LONG);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SPAN; k++) begin
                for (int p = 0; p < PH_LONG; p++) begin
                    mem[k][p] <= '0;
                end
            end
        end else if (wr_ok) begin
            mem[wr_ui][wr_ph] <= wr_data;
        end
    end

    // One read port per UI offset, all at the same phase
    for (genvar k = 0; k < SPAN; k++) begin : g_rd
        assign rd_amp[k] = (32'(rd_ph) < PH_LONG) ? mem[k][rd_ph] : '0;
    end

endmodule

// File: rtl/pps_sum_sat.sv
`timescale 1ns/1ps
module pps_sum_sat #(
    parameter int AMP_W = 8,
    parameter int SPAN  = 5,
    localparam int SUM_W = AMP_W + $clog2(SPAN) + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    input  logic                          active,
    input  logic                          ovf_clr,
    input  pps_pkg::pol_t [SPAN-1:0]      hist,
    input  logic [SPAN-1:0][AMP_W-1:0]    rd_amp,
    output logic [AMP_W-1:0]              amp_q,
    output logic                          stb_q,
    output logic                          ovf_q
);

    localparam logic signed [SUM_W-1:0] POS_FS =
        {{(SUM_W-AMP_W+1){1'b0}}, {(AMP_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] NEG_FS =
        {{(SUM_W-AMP_W+1){1'b1}}, {(AMP_W-1){1'b0}}};

    logic signed [SUM_W-1:0] term [SPAN];
    logic signed [SUM_W-1:0] sum_c;
    logic [AMP_W-1:0]        sat_c;
    logic                    clip_c;

    // Signed contribution of each UI offset
    for (genvar k = 0; k < SPAN; k++) begin : g_term
        logic signed [SUM_W-1:0] ext;
        assign ext = {{(SUM_W-AMP_W){rd_amp[k][AMP_W-1]}}, rd_amp[k]};
        assign term[k] = !hist[k].mark ? '0 : (hist[k].neg ? -ext : ext);
    end

    always_comb begin
        sum_c = '0;
        for (int k = 0; k < SPAN; k++) begin
            sum_c = sum_c + term[k];
        end
        clip_c = 1'b0;
        if (sum_c > POS_FS) begin
            sat_c  = POS_FS[AMP_W-1:0];
            clip_c = 1'b1;
        end else if (sum_c < NEG_FS) begin
            sat_c  = NEG_FS[AMP_W-1:0];
            clip_c = 1'b1;
        end else begin
            sat_c  = sum_c[AMP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_q <= '0;
            stb_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            stb_q <= tick;
            if (tick) begin
                amp_q <= active ? sat_c : '0;
            end
            // A clamp in the same cycle wins over a clear
            ovf_q <= (tick & active & clip_c) | (ovf_q & ~ovf_clr);
        end
    end

endmodule

// File: rtl/pulse_phase_seq.sv
`timescale 1ns/1ps
module pulse_phase_seq #(
    parameter int AMP_W    = 8,
    parameter int SPAN     = 5,
    parameter int PH_LONG  = 14,
    parameter int PH_SHORT = 13,
    localparam int UI_W    = $clog2(SPAN),
    localparam int PH_W    = $clog2(PH_LONG),
    localparam int CFG_W   = pps_pkg::CFG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               phase_tick,
    input  logic               tx_mark,
    input  logic [CFG_W-1:0]   line_cfg,
    input  logic               tbl_wr_en,
    input  logic [UI_W-1:0]    tbl_wr_ui,
    input  logic [PH_W-1:0]    tbl_wr_ph,
    input  logic [AMP_W-1:0]   tbl_wr_data,
    input  logic               ovf_clr,
    output logic [AMP_W-1:0]   amp_out,
    output logic               amp_stb,
    output logic               ovf_flag
);
    import pps_pkg::*;

    mode_t                       mode_c;
    logic                        arb_active;
    logic [PH_W-1:0]             ph_q;
    logic [PH_W-1:0]             ph_nxt;
    logic                        wrap_c;
    pol_t [SPAN-1:0]             hist_q;
    pol_t [SPAN-1:0]             hist_nxt;
    logic [SPAN-1:0][AMP_W-1:0]  rd_amp;

    assign mode_c     = decode_cfg(line_cfg);
    assign arb_active = (mode_c != MODE_OFF);

    pps_phase_ctr #(
        .PH_LONG (PH_LONG),
        .PH_SHORT(PH_SHORT)
    ) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .tick  (phase_tick),
        .mode  (mode_c),
        .ph_q  (ph_q),
        .ph_nxt(ph_nxt),
        .wrap  (wrap_c)
    );

    pps_mark_hist #(
        .SPAN(SPAN)
    ) u_hist (
        .clk     (clk),
        .rst     (rst),
        .tick    (phase_tick),
        .wrap    (wrap_c),
        .active  (arb_active),
        .mark    (tx_mark),
        .hist_q  (hist_q),
        .hist_nxt(hist_nxt)
    );

    pps_wave_tbl #(
        .AMP_W  (AMP_W),
        .SPAN   (SPAN),
        .PH_LONG(PH_LONG)
    ) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tbl_wr_en),
        .wr_ui  (tbl_wr_ui),
        .wr_ph  (tbl_wr_ph),
        .wr_data(tbl_wr_data),
        .rd_ph  (ph_nxt),
        .rd_amp (rd_amp)
    );

    pps_sum_sat #(
        .AMP_W(AMP_W),
        .SPAN (SPAN)
    ) u_sum (
        .clk    (clk),
        .rst    (rst),
        .tick   (phase_tick),
        .active (arb_active),
        .ovf_clr(ovf_clr),
        .hist   (hist_nxt),
        .rd_amp (rd_amp),
        .amp_q  (amp_out),
        .stb_q  (amp_stb),
        .ovf_q  (ovf_flag)
    );

endmodule

// File: rtl/pps_chk.sv
`timescale 1ns/1ps
module pps_chk #(
    parameter int AMP_W   = 8,
    parameter int PH_LONG = 14,
    parameter int PH_W    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             phase_tick,
    input logic             tx_mark,
    input logic             ovf_clr,
    input logic             arb_active,
    input logic             wrap,
    input logic [PH_W-1:0]  ph_q,
    input logic             hist0_mark,
    input logic [AMP_W-1:0] amp_out,
    input logic             amp_stb,
    input logic             ovf_flag
);

    p_stb_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
        phase_tick |=> amp_stb);

    p_no_stray_stb_r2: assert property (@(posedge clk) disable iff (rst)
        !phase_tick |=> !amp_stb);

    p_amp_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !phase_tick |=> $stable(amp_out));

    p_phase_range_r3: assert property (@(posedge clk) disable iff (rst)
        32'(ph_q) < PH_LONG);

    p_off_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_tick && !arb_active) |=> (amp_out == '0));

    p_off_no_ovf_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_tick && !arb_active && !ovf_flag) |=> !ovf_flag);

    p_launch_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_tick && arb_active && wrap && tx_mark) |=> hist0_mark);

    p_space_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_tick && arb_active && wrap && !tx_mark) |=> !hist0_mark);

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_ovf_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(phase_tick));

endmodule

bind pulse_phase_seq pps_chk #(
    .AMP_W  (AMP_W),
    .PH_LONG(PH_LONG),
    .PH_W   (PH_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase_tick(phase_tick),
    .tx_mark   (tx_mark),
    .ovf_clr   (ovf_clr),
    .arb_active(arb_active),
    .wrap      (wrap_c),
    .ph_q      (ph_q),
    .hist0_mark(hist_q[0].mark),
    .amp_out   (amp_out),
    .amp_stb   (amp_stb),
    .ovf_flag  (ovf_flag)
);

// File: tb/pulse_phase_seq_tb.sv
`timescale 1ns/1ps
module pulse_phase_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       phase_tick = 1'b0;
    logic       tx_mark = 1'b0;
    logic [3:0] line_cfg = 4'b1010;
    logic       tbl_wr_en = 1'b0;
    logic [2:0] tbl_wr_ui = '0;
    logic [3:0] tbl_wr_ph = '0;
    logic [7:0] tbl_wr_data = '0;
    logic       ovf_clr = 1'b0;
    logic [7:0] amp_out;
    logic       amp_stb;
    logic       ovf_flag;

    always #4 clk = ~clk;

    pulse_phase_seq dut_i (
        .clk        (clk),
        .rst        (rst),
        .phase_tick (phase_tick),
        .tx_mark    (tx_mark),
        .line_cfg   (line_cfg),
        .tbl_wr_en  (tbl_wr_en),
        .tbl_wr_ui  (tbl_wr_ui),
        .tbl_wr_ph  (tbl_wr_ph),
        .tbl_wr_data(tbl_wr_data),
        .ovf_clr    (ovf_clr),
        .amp_out    (amp_out),
        .amp_stb    (amp_stb),
        .ovf_flag   (ovf_flag)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // Reference model state
    int tbl [5][14];
    int m_ph = 0;
    int m_hist [5];
    bit m_neg = 0;
    bit m_ovf = 0;

    int exp_amp_q [$];
    int exp_ovf_q [$];

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_neg = 0; m_ovf = 0;
        foreach (m_hist[k]) m_hist[k] = 0;
        foreach (tbl[k, p]) tbl[k][p] = 0;
    endtask

    task automatic wr(int k, int p, int v);
        @(negedge clk);
        tbl_wr_en   = 1'b1;
        tbl_wr_ui   = 3'(k);
        tbl_wr_ph   = 4'(p);
        tbl_wr_data = 8'(v);
        if (k < 5 && p < 14) tbl[k][p] = v;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // Driver: one phase tick, expected result pushed to the scoreboard
    task automatic tick(bit m, bit clr = 1'b0);
        bit act;
        int n, np, sum, s;
        bit wrp, clip;
        @(negedge clk);
        phase_tick = 1'b1;
        tx_mark    = m;
        ovf_clr    = clr;
        act = (line_cfg == 4'b1001) || (line_cfg == 4'b1010) || (line_cfg == 4'b1011);
        n   = (line_cfg == 4'b1001) ? 13 : 14;
        wrp = (m_ph >= n - 1);
        np  = wrp ? 0 : m_ph + 1;
        if (!act) begin
            foreach (m_hist[k]) m_hist[k] = 0;
        end else if (wrp) begin
            for (int k = 4; k > 0; k--) m_hist[k] = m_hist[k-1];
            s = m ? (m_neg ? -1 : 1) : 0;
            if (m) m_neg = !m_neg;
            m_hist[0] = s;
        end
        sum = 0;
        for (int k = 0; k < 5; k++) sum += m_hist[k] * tbl[k][np];
        clip = 1'b0;
        if (sum > 127) begin sum = 127; clip = 1'b1; end
        if (sum < -128) begin sum = -128; clip = 1'b1; end
        m_ovf = (act && clip) || (m_ovf && !clr);
        m_ph = np;
        exp_amp_q.push_back(sum);
        exp_ovf_q.push_back(int'(m_ovf));
        @(negedge clk);
        phase_tick = 1'b0;
        ovf_clr    = 1'b0;
        tx_mark    = 1'b0;
    endtask

    task automatic send_ui(bit m, int nph);
        for (int i = 0; i < nph; i++) tick((i == nph - 1) ? m : 1'b0);
    endtask

    task automatic clear_ovf();
        @(negedge clk);
        ovf_clr = 1'b1;
        m_ovf = 0;
        @(negedge clk);
        ovf_clr = 1'b0;
        check("R9 clear", int'(ovf_flag), 0);
    endtask

    // Monitor: compares each strobed result with the scoreboard
    logic [7:0] last_amp = '0;
    always @(negedge clk) begin
        if (rst) begin
            last_amp = amp_out;
        end else begin
            if (amp_stb) begin
                if (exp_amp_q.size() == 0) begin
                    check({cur_req, " R2 unexpected strobe"}, 1, 0);
                end else begin
                    int ea, eo;
                    ea = exp_amp_q.pop_front();
                    eo = exp_ovf_q.pop_front();
                    check({cur_req, " amp"}, int'($signed(amp_out)), ea);
                    check({cur_req, " R9 ovf"}, int'(ovf_flag), eo);
                end
            end else if (amp_out !== last_amp) begin
                check("R2 amp changed without strobe", int'($signed(amp_out)), int'($signed(last_amp)));
            end
            last_amp = amp_out;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 amp", int'(amp_out), 0);
        check("R1 stb", int'(amp_stb), 0);
        check("R1 ovf", int'(ovf_flag), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 amp after release", int'(amp_out), 0);
        check("R1 ovf after release", int'(ovf_flag), 0);

        // R10: table load, with writes outside the range that must be dropped
        cur_req = "R10";
        for (int k = 0; k < 5; k++)
            for (int p = 0; p < 14; p++)
                wr(k, p, p * 3 - k * 5 - 7);
        wr(5, 0, 99);
        wr(7, 3, 99);
        wr(0, 14, 99);
        wr(2, 15, 99);

        // R11 and R5: marks held high before the first wrap are not taken
        cur_req = "R11 R5";
        line_cfg = 4'b1010;
        for (int i = 0; i < 14; i++) tick(1'b1);
        send_ui(1'b0, 14);

        // R6 and R7: mixed patterns, overlapping tails, alternating polarity
        cur_req = "R6 R7";
        begin
            bit pat [12] = '{1, 0, 1, 1, 0, 0, 1, 1, 1, 0, 0, 0};
            foreach (pat[i]) send_ui(pat[i], 14);
        end
        for (int i = 0; i < 6; i++) send_ui(1'b0, 14);

        // R3: second 14-phase code, then the 13-phase code with phase 13 loaded at full scale
        cur_req = "R3 long";
        line_cfg = 4'b1011;
        send_ui(1'b1, 14);
        send_ui(1'b1, 14);
        send_ui(1'b0, 14);
        cur_req = "R3 short";
        for (int k = 0; k < 5; k++) wr(k, 13, 127);
        line_cfg = 4'b1001;
        for (int i = 0; i < 8; i++) send_ui(i % 3 != 2, 13);
        for (int i = 0; i < 6; i++) send_ui(1'b0, 13);

        // R4: codes that turn shaping off
        cur_req = "R4";
        line_cfg = 4'b0000;
        send_ui(1'b1, 14);
        send_ui(1'b1, 14);
        line_cfg = 4'b1000;
        send_ui(1'b1, 14);
        line_cfg = 4'b1111;
        send_ui(1'b1, 14);
        check("R4 ovf idle", int'(ovf_flag), 0);
        line_cfg = 4'b1010;
        send_ui(1'b0, 14);
        send_ui(1'b1, 14);
        for (int i = 0; i < 5; i++) send_ui(1'b0, 14);

        // R8 and R9: offsets with alternating sign so consecutive marks add up
        cur_req = "R8 R9";
        for (int k = 0; k < 5; k++)
            for (int p = 0; p < 14; p++)
                wr(k, p, (k % 2 == 0) ? 100 : -100);
        send_ui(1'b1, 14);
        send_ui(1'b1, 14);
        send_ui(1'b1, 14);
        check("R9 flag set after clamp", int'(ovf_flag), 1);
        clear_ovf();
        // A clear and a clamp in the same cycle: the flag stays set
        tick(1'b0, 1'b1);
        check("R9 set wins", int'(ovf_flag), 1);
        for (int i = 0; i < 7; i++) send_ui(1'b0, 14);
        clear_ovf();
        send_ui(1'b0, 14);
        check("R9 stays clear", int'(ovf_flag), 0);

        repeat (4) @(negedge clk);
        check("R2 scoreboard drained", exp_amp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule